// File: doc/BRIEF.md
# Half-Duplex Synchronous Programming-Link Transceiver

This block drives a free-running programming clock and moves 12-bit character frames over one shared data wire. A frame carries a low start bit, eight data bits sent least-significant first, an even-parity bit and two high stop bits. The host side offers a byte (or an idle-frame request) through a valid/ready handshake, or asks for a byte to be received. Received bytes come back as a one-cycle `rx_valid` pulse with the data and a parity-mismatch flag.

The wire is driven only while the block talks. The block itself decides when the line changes hands. When it turns the line round to drive, it first waits one whole programming-clock period. It then sets its output high and only after that enables the driver. When it turns the line round to listen, it releases the driver and waits until the far end pulls the wire high. Waits that depend on the far end run against a tick-counted timeout. When the timeout runs out, the block raises a `timeout` pulse and goes back to idle.

Top module: `prog_link_xcvr`

## Requirements
- R1: The programming clock `pclk_out` is low after reset and toggles once every `div_val`+1 system clock cycles, so its period is 2*(`div_val`+1) cycles.
- R2: A transmitted byte D appears on the line as 12 bits, least-significant first. Bit 0 is the start bit (0), bits 1..8 are D[0]..D[7], bit 9 is the XOR of all bits of D, and bits 10 and 11 are 1.
- R3: While transmitting, the line only changes at a falling edge of `pclk_out`, and it holds its value through the high phase of the clock.
- R4: While receiving, the line is sampled at rising edges of `pclk_out`. High samples taken before the first low sample are ignored, and the low sample counts as the start bit.
- R5: A received frame yields `rx_data` = its bits 1..8, and `rx_valid` is high for exactly one cycle per frame.
- R6: `parity_error` is 1 when received bit 9 differs from the XOR of the received data bits. The byte is delivered either way.
- R7: With `tx_break` high during the transmit handshake, a full 12-bit frame is sent with the line driven high throughout.
- R8: `data_oe` is 0 after reset. When the block turns the line round from listening to driving, it first waits two clock ticks, and `data_out` is already 1 in the cycle in which `data_oe` rises.
- R9: When a receive is requested while driving, `data_oe` drops. No bit is taken until the line has been seen high.
- R10: A receive or listen turnaround that has not finished within `TIMEOUT_TICKS` clock ticks of its start raises `timeout` for one cycle and returns the block to idle without delivering a byte.
- R11: `tx_ready` is high only while idle, and `busy` is high from the accepted request until the frame (or its abort) is complete. A request to transmit takes precedence over a request to receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Programming-clock tick spacing minus one, in system cycles |
| tx_valid | input | 1 | Transmit request valid |
| tx_break | input | 1 | With tx_valid: send an all-high idle frame instead of tx_data |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Block idle; a transmit or receive request is taken this cycle |
| rx_req | input | 1 | Request to receive one byte (taken when tx_ready and no tx_valid) |
| rx_valid | output | 1 | One-cycle pulse: rx_data and parity_error are new |
| rx_data | output | 8 | Last received byte |
| parity_error | output | 1 | Parity mismatch on the last received frame |
| timeout | output | 1 | One-cycle pulse: a receive or turnaround wait expired |
| busy | output | 1 | A frame or turnaround is in progress |
| pclk_out | output | 1 | Programming clock to the target |
| data_out | output | 1 | Value driven onto the data line |
| data_oe | output | 1 | Driver enable for the data line |
| data_in | input | 1 | Sampled level of the data line |

## Verification
A wrong bit count or a wrong shift register shows up within one frame, as a misplaced start bit or a wrong parity or stop bit on the captured line. On the receive side the same fault gives a wrong `rx_data` at the `rx_valid` pulse. A direction flag stuck at the wrong value shows up at the next request: `data_oe` either never rises or fails to drop, or the line is sampled while the far end still holds it low, and that corrupts the returned byte. A faulty timer shows up as a `timeout` pulse outside the window of `TIMEOUT_TICKS` ticks, measured from the request.

// File: rtl/plx_pkg.sv
`timescale 1ns/1ps
package plx_pkg;
    localparam int FRAME_BITS = 12;
    localparam int DATA_BITS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TURN_TX, ST_DRIVE_ON, ST_TX, ST_TURN_RX, ST_RX
    } plx_state_t;

    // bit 0 (start) is the first on the wire
    typedef struct packed {
        logic                 stop_b;
        logic                 stop_a;
        logic                 parity;
        logic [DATA_BITS-1:0] data;
        logic                 start;
    } plx_frame_t;

    localparam plx_frame_t IDLE_FRAME = '1;

    function automatic plx_frame_t make_frame(input logic [DATA_BITS-1:0] d);
        plx_frame_t f;
        f.start  = 1'b0;
        f.data   = d;
        f.parity = ^d;
        f.stop_a = 1'b1;
        f.stop_b = 1'b1;
        return f;
    endfunction

    function automatic logic parity_bad(input plx_frame_t f);
        return f.parity ^ (^f.data);
    endfunction
endpackage

// File: rtl/plx_clkdiv.sv
`timescale 1ns/1ps
module plx_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    output logic             pclk,
    output logic             tick_rise,
    output logic             tick_fall
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick      = (cnt >= div_val);
    assign tick_rise = tick & ~pclk;
    assign tick_fall = tick &  pclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            pclk <= ~pclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R1: the clock only moves on a divider tick
    a_r1_pclk_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(pclk) |-> $past(tick));
endmodule

// File: rtl/plx_timeout.sv
`timescale 1ns/1ps
module plx_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LOAD = CW'(LIMIT);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                              remain <= LOAD;
        else if (reload)                      remain <= LOAD;
        else if (run && tick && remain != '0) remain <= remain - 1'b1;
    end

    assign expired = run && (remain == '0);

    // R10: the remaining budget never exceeds the limit
    a_r10_budget_bound: assert property (@(posedge clk) disable iff (rst)
        remain <= LOAD);
endmodule

// File: rtl/prog_link_xcvr.sv
`timescale 1ns/1ps
module prog_link_xcvr
    import plx_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             tx_valid,
    input  logic             tx_break,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    input  logic             rx_req,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             parity_error,
    output logic             timeout,
    output logic             busy,
    output logic             pclk_out,
    output logic             data_out,
    output logic             data_oe,
    input  logic             data_in
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    plx_state_t             state;
    logic                   dir_tx;
    logic [FRAME_BITS-1:0]  sr;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   turn_half;
    logic                   tick_rise, tick_fall, tick_any;
    logic                   expired, t_reload, t_run;
    logic [FRAME_BITS-1:0]  rx_next;
    plx_frame_t             rx_f;

    plx_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .div_val(div_val),
        .pclk(pclk_out), .tick_rise(tick_rise), .tick_fall(tick_fall)
    );

    assign tick_any = tick_rise | tick_fall;

    assign t_run    = (state == ST_TURN_RX) || (state == ST_RX);
    assign t_reload = ((state == ST_IDLE) && (tx_valid || rx_req))
                    || (state == ST_DRIVE_ON)
                    || ((state == ST_TURN_RX) && data_in && !expired);

    plx_timeout #(.LIMIT(TIMEOUT_TICKS)) u_tmo (
        .clk(clk), .rst(rst), .reload(t_reload), .run(t_run),
        .tick(tick_any), .expired(expired)
    );

    assign rx_next  = {data_in, sr[FRAME_BITS-1:1]};
    assign rx_f     = plx_frame_t'(rx_next);
    assign tx_ready = (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            dir_tx       <= 1'b0;
            sr           <= '1;
            bit_cnt      <= '0;
            turn_half    <= 1'b0;
            data_out     <= 1'b0;
            data_oe      <= 1'b0;
            rx_data      <= '0;
            parity_error <= 1'b0;
            rx_valid     <= 1'b0;
            timeout      <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            timeout  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tx_valid) begin
                        sr        <= tx_break ? IDLE_FRAME : make_frame(tx_data);
                        bit_cnt   <= FULL;
                        turn_half <= 1'b0;
                        state     <= dir_tx ? ST_TX : ST_TURN_TX;
                    end else if (rx_req) begin
                        bit_cnt <= FULL;
                        if (dir_tx) begin
                            data_oe  <= 1'b0;
                            data_out <= 1'b0;
                            dir_tx   <= 1'b0;
                            state    <= ST_TURN_RX;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_TURN_TX: begin
                    // one full clock period = two ticks
                    if (tick_any) begin
                        turn_half <= 1'b1;
                        if (turn_half) begin
                            data_out <= 1'b1;
                            state    <= ST_DRIVE_ON;
                        end
                    end
                end
                ST_DRIVE_ON: begin
                    data_oe <= 1'b1;
                    dir_tx  <= 1'b1;
                    state   <= ST_TX;
                end
                ST_TX: begin
                    if (tick_fall) begin
                        if (bit_cnt != '0) begin
                            data_out <= sr[0];
                            sr       <= {1'b1, sr[FRAME_BITS-1:1]};
                            bit_cnt  <= bit_cnt - 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_TURN_RX: begin
                    if (expired) begin
                        timeout <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (data_in) begin
                        state <= ST_RX;
                    end
                end
                ST_RX: begin
                    if (expired) begin
                        timeout <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (tick_rise && !((bit_cnt == FULL) && data_in)) begin
                        sr      <= rx_next;
                        bit_cnt <= bit_cnt - 1'b1;
                        if (bit_cnt == CNT_W'(1)) begin
                            rx_data      <= rx_f.data;
                            parity_error <= parity_bad(rx_f);
                            rx_valid     <= 1'b1;
                            state        <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: output already high when the driver turns on
    a_r8_oe_rise_high: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> data_out);

    // R3: a driven line changes only on a falling-edge tick
    a_r3_tx_on_fall: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past(data_oe) && !$stable(data_out)) |-> $past(tick_fall));

    // R5: a delivered byte is a single-cycle pulse
    a_r5_rx_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4: bytes are completed by a rising-edge sample
    a_r4_rx_on_rise: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(tick_rise));

    // R10: an abort leaves the block idle
    a_r10_timeout_idle: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (!busy && !rx_valid));
endmodule

// File: tb/prog_link_xcvr_tb_top.sv
`timescale 1ns/1ps
module prog_link_xcvr_tb_top;
    localparam int DIV_W = 8;
    localparam int TMO   = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_val = 8'd3;
    logic             tx_valid = 1'b0, tx_break = 1'b0, rx_req = 1'b0;
    logic [7:0]       tx_data = 8'h00;
    logic             tx_ready, rx_valid, parity_error, timeout, busy;
    logic [7:0]       rx_data;
    logic             pclk_out, data_out, data_oe;
    logic             tgt = 1'b1;
    wire              line = data_oe ? data_out : tgt;

    int n_chk = 0, n_fail = 0;
    int rx_count = 0, tmo_count = 0;
    logic [7:0] last_rx = 8'h00;
    logic       last_perr = 1'b0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    prog_link_xcvr #(.DIV_W(DIV_W), .TIMEOUT_TICKS(TMO)) dut_i (
        .clk(clk), .rst(rst), .div_val(div_val),
        .tx_valid(tx_valid), .tx_break(tx_break), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_req(rx_req), .rx_valid(rx_valid),
        .rx_data(rx_data), .parity_error(parity_error), .timeout(timeout),
        .busy(busy), .pclk_out(pclk_out), .data_out(data_out),
        .data_oe(data_oe), .data_in(line)
    );

    always @(posedge clk) begin
        if (!rst && rx_valid) begin
            rx_count  <= rx_count + 1;
            last_rx   <= rx_data;
            last_perr <= parity_error;
        end
        if (!rst && timeout) tmo_count <= tmo_count + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        check(pclk_out == 1'b0, "R1", "pclk after reset", pclk_out, 0);
        check(data_oe == 1'b0, "R8", "oe after reset", data_oe, 0);
        check(busy == 1'b0 && tx_ready == 1'b1, "R11", "idle after reset", {busy, tx_ready}, 1);
        check(rx_valid == 1'b0 && timeout == 1'b0, "R5", "no pulses after reset", {rx_valid, timeout}, 0);
    endtask

    task automatic t_clock(input int d);
        time t0, t1;
        div_val = DIV_W'(d);
        repeat (3) @(posedge pclk_out);
        t0 = $time;
        @(posedge pclk_out);
        t1 = $time;
        check((t1 - t0) == 2 * (d + 1) * 4, "R1", "pclk period ns", int'(t1 - t0), 2 * (d + 1) * 4);
    endtask

    task automatic t_send(input logic [7:0] b, input bit brk);
        logic [11:0] exp, got;
        bit stable_ok = 1'b1, busy_ok = 1'b1, oe_ok = 1'b1;
        int k = 0;
        exp = brk ? 12'hFFF : {2'b11, ^b, b, 1'b0};
        @(negedge clk);
        tx_valid = 1'b1; tx_data = b; tx_break = brk;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0; tx_break = 1'b0;
        check(busy == 1'b1 && tx_ready == 1'b0, "R11", "busy after tx accept", {busy, tx_ready}, 2);
        while (!data_oe && k < 400) begin @(negedge clk); k++; end
        check(data_oe == 1'b1, "R8", "driver enabled", data_oe, 1);
        check(data_out == 1'b1, "R8", "line high as driver turns on", data_out, 1);
        @(negedge pclk_out);
        for (int i = 0; i < 12; i++) begin
            @(posedge pclk_out);
            #1;
            got[i] = line;
            if (!busy) busy_ok = 1'b0;
            if (!data_oe) oe_ok = 1'b0;
            #4;
            if (line != got[i]) stable_ok = 1'b0;
        end
        check(got == exp, brk ? "R7" : "R2", "frame on line", got, exp);
        check(stable_ok, "R3", "line steady in high phase", stable_ok, 1);
        check(busy_ok && oe_ok, "R11", "busy and oe through frame", {busy_ok, oe_ok}, 3);
        k = 0;
        while (busy && k < 400) begin @(negedge clk); k++; end
        check(!busy && tx_ready, "R11", "idle after frame", {busy, tx_ready}, 1);
    endtask

    task automatic t_recv(input logic [11:0] f, input int pre, input int hold_low,
                          input logic [7:0] exp_d, input bit exp_p);
        int c0, k;
        c0 = rx_count;
        tgt = (hold_low > 0) ? 1'b0 : 1'b1;
        @(negedge clk);
        rx_req = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        rx_req = 1'b0;
        check(busy == 1'b1, "R11", "busy after rx accept", busy, 1);
        if (hold_low > 0) begin
            repeat (hold_low) @(negedge clk);
            check(data_oe == 1'b0, "R9", "driver released", data_oe, 0);
            check(busy == 1'b1 && rx_count == c0, "R9", "still waiting for high line", rx_count - c0, 0);
            tgt = 1'b1;
        end
        for (int i = 0; i < pre; i++) begin @(negedge pclk_out); #1; tgt = 1'b1; end
        for (int i = 0; i < 12; i++) begin @(negedge pclk_out); #1; tgt = f[i]; end
        @(negedge pclk_out); #1; tgt = 1'b1;
        k = 0;
        while (rx_count == c0 && k < 400) begin @(negedge clk); k++; end
        check(rx_count == c0 + 1, "R5", "one byte delivered", rx_count - c0, 1);
        check(last_rx == exp_d, "R5", "received byte", last_rx, exp_d);
        check(last_perr == exp_p, "R6", "parity flag", last_perr, exp_p);
        check(!busy, "R11", "idle after receive", busy, 0);
    endtask

    task automatic t_timeout(input bit low_line, input int d);
        int c0, r0, k;
        c0 = tmo_count; r0 = rx_count;
        tgt = low_line ? 1'b0 : 1'b1;
        @(negedge clk);
        rx_req = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        rx_req = 1'b0;
        k = 1;
        while (tmo_count == c0 && k < 4000) begin @(negedge clk); k++; end
        check(tmo_count == c0 + 1, "R10", "timeout pulse", tmo_count - c0, 1);
        check(k >= (TMO - 1) * (d + 1) && k <= TMO * (d + 1) + 4, "R10", "timeout cycles",
              k, TMO * (d + 1));
        check(!busy && rx_count == r0, "R10", "idle, no byte", {busy, 8'(rx_count - r0)}, 0);
        if (low_line) check(data_oe == 1'b0, "R9", "released during stuck turnaround", data_oe, 0);
        tgt = 1'b1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_clock(3);
        t_send(8'hA5, 1'b0);
        t_send(8'h00, 1'b0);
        t_send(8'h00, 1'b1);
        t_recv({2'b11, 1'b0, 8'h3C, 1'b0}, 0, 40, 8'h3C, 1'b0);
        t_recv({2'b11, 1'b1, 8'h81, 1'b0}, 3, 0, 8'h81, 1'b1);
        t_send(8'hFF, 1'b0);
        t_timeout(1'b0, 3);
        t_send(8'h7E, 1'b0);
        t_timeout(1'b1, 3);
        t_clock(1);
        t_recv({2'b11, 1'b0, 8'hFF, 1'b0}, 2, 0, 8'hFF, 1'b0);
        t_send(8'h5A, 1'b0);
        t_recv({2'b11, 1'b1, 8'hC3, 1'b0}, 1, 20, 8'hC3, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule